// File: doc/BRIEF.md
# Four-Phase Accumulator Instruction Executor

This block runs two byte-wide register-file instructions against a working register. The first adds the working register, a data-memory byte and the carry flag; the result goes either back to the working register or to the memory byte. The second ANDs the working register with an 8-bit literal carried in the instruction. The block holds the working register, a five-bit status register and a bank register. It drives a single-port, byte-wide data memory whose read data comes back one cycle after the address.

An instruction word enters through a valid/ready handshake. Every instruction then takes four phases:

- decode and present the address;
- capture the operand;
- compute;
- write the destination.

`instr_ready` is high while the block is idle and during the fourth phase, so a new word can be taken on the same edge that retires the previous one. While `instr_ready` is low, the source must hold `instr_valid` and `instr_word` steady. Back-pressure costs nothing: a word that is not taken has no effect. The bank register is loaded through a plain strobe.

Top module: `wexec_core`

## Requirements
- R1: `instr_ready` is high exactly when the block is idle or in its fourth phase. A word is taken only on a clock edge where `instr_valid` and `instr_ready` are both high. A word offered while `instr_ready` is low has no effect.
- R2: `done` is high for one cycle. That cycle is the fourth cycle after the edge that took the word.
- R3: Bits [15:10] = 001000 encode the add-with-carry. Bit 9 is the destination bit d, bit 8 is the bank bit a, and bits [7:0] are the file address. The result is W + file byte + C, modulo 256.
- R4: With d=0 the add result goes to W and memory is not written. With d=1 it is written to the addressed byte and W keeps its value.
- R5: With a=0, file addresses 00h–5Fh map to memory address 000h–05Fh, and 60h–FFh map to F60h–FFFh.
- R6: With a=1, the memory address is {bank register[3:0], file address}. The bank register loads from `bsr_wr_data` on any edge where `bsr_wr_en` is high. The bank is sampled on the edge that takes the word, so a load on that same edge applies only to later words.
- R7: The status bits are [0]=C, [1]=DC, [2]=Z, [3]=OV, [4]=N. After an add:
  - C is the carry out of bit 7;
  - DC is the carry out of bit 3;
  - Z is set when the result is zero;
  - OV is set on signed two's-complement overflow;
  - N is result bit 7.
- R8: Bits [15:8] = 0Bh encode AND-literal, with the literal k in [7:0]. W becomes W AND k. Only N and Z are updated; C, DC and OV keep their values.
- R9: Any other word is a no-operation. It still takes four phases and raises `done`, but it accesses no memory and changes neither W nor the status register.
- R10: `mem_rd_en` is high only in the first phase of an add. `mem_wr_en` is high only in the fourth phase of an add with d=1. `mem_addr` holds one value from the first through the fourth phase. A read in the first phase of a word taken back-to-back sees the data written in the previous word's fourth phase.
- R11: After reset, W, the status register and the bank register are 0, `done` is low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block can take a word this cycle |
| instr_word | input | 16 | Instruction word |
| bsr_wr_en | input | 1 | Load strobe for the bank register |
| bsr_wr_data | input | 4 | New bank register value |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| w_out | output | 8 | Working register |
| status_out | output | 5 | Status register {N, OV, Z, DC, C} |
| done | output | 1 | Fourth phase of an instruction |

## Verification
Two pairs of functions can fall in the same cycle.

- **Retire and accept.** One word's fourth-phase write-back can coincide with the acceptance of the next word. The bench issues an add with d=1 and, back-to-back, an add that reads the same byte. It checks that the second read returns the freshly written value.
- **Bank load and accept.** A bank-register load can coincide with the acceptance of a banked add. The bench drives both on one edge and checks that the presented address still uses the old bank, while the next word uses the new one.

A behavioural model tracks the expected phase, address, write data, W and status. Both scenarios are judged against it on every clock.

// File: rtl/wexec_pkg.sv
package wexec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_Q1   = 3'd1,
    PH_Q2   = 3'd2,
    PH_Q3   = 3'd3,
    PH_Q4   = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADDC = 2'd1,
    OP_ANDL = 2'd2
  } op_t;

  // packed MSB first: status bit 4 = n ... bit 0 = c
  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  localparam logic [5:0] ADDC_PATTERN = 6'b001000;
  localparam logic [7:0] ANDL_PATTERN = 8'h0B;

endpackage

// File: rtl/wexec_decode.sv
module wexec_decode import wexec_pkg::*; #(
  parameter int DW = 8
) (
  input  logic [DW+7:0] word,
  output op_t           op,
  output logic          dest_file,
  output logic          use_bank,
  output logic [DW-1:0] field
);
  localparam int IW = DW + 8;

  always_comb begin
    if (word[IW-1 -: 6] == ADDC_PATTERN) begin
      op = OP_ADDC;
    end else if (word[IW-1 -: 8] == ANDL_PATTERN) begin
      op = OP_ANDL;
    end else begin
      op = OP_NOP;
    end
  end

  assign dest_file = word[DW+1];
  assign use_bank  = word[DW];
  assign field     = word[DW-1:0];

endmodule

// File: rtl/wexec_bankmap.sv
module wexec_bankmap #(
  parameter int DW           = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 'h60
) (
  input  logic [DW-1:0]        field,
  input  logic                 use_bank,
  input  logic [BANK_W-1:0]    bank,
  output logic [BANK_W+DW-1:0] addr
);
  localparam logic [DW-1:0] SPLIT_V = DW'(ACCESS_SPLIT);

  logic [BANK_W-1:0] access_bank;

  generate
    if (ACCESS_SPLIT <= 0) begin : g_all_high
      assign access_bank = '1;
    end else begin : g_split
      assign access_bank = (field < SPLIT_V) ? '0 : '1;
    end
  endgenerate

  assign addr = use_bank ? {bank, field} : {access_bank, field};

endmodule

// File: rtl/wexec_alu.sv
module wexec_alu import wexec_pkg::*; #(
  parameter int DW = 8
) (
  input  op_t           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] opnd,
  input  flags_t        flags_in,
  output logic [DW-1:0] result,
  output flags_t        flags_out
);
  localparam int H = DW / 2;

  logic [DW:0] sum_full;
  logic [H:0]  sum_half;
  logic [DW-1:0] and_res;

  assign sum_full = {1'b0, w} + {1'b0, opnd} + {{DW{1'b0}}, flags_in.c};
  assign sum_half = {1'b0, w[H-1:0]} + {1'b0, opnd[H-1:0]} + {{H{1'b0}}, flags_in.c};
  assign and_res  = w & opnd;

  always_comb begin
    result    = w;
    flags_out = flags_in;
    unique case (op)
      OP_ADDC: begin
        result       = sum_full[DW-1:0];
        flags_out.c  = sum_full[DW];
        flags_out.dc = sum_half[H];
        flags_out.z  = (sum_full[DW-1:0] == '0);
        flags_out.n  = sum_full[DW-1];
        flags_out.ov = (w[DW-1] == opnd[DW-1]) && (sum_full[DW-1] != w[DW-1]);
      end
      OP_ANDL: begin
        result      = and_res;
        flags_out.z = (and_res == '0);
        flags_out.n = and_res[DW-1];
      end
      default: begin
        result    = w;
        flags_out = flags_in;
      end
    endcase
  end

endmodule

// File: rtl/wexec_core.sv
module wexec_core import wexec_pkg::*; #(
  parameter int DW           = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 'h60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  output logic                 instr_ready,
  input  logic [DW+7:0]        instr_word,
  input  logic                 bsr_wr_en,
  input  logic [BANK_W-1:0]    bsr_wr_data,
  output logic [BANK_W+DW-1:0] mem_addr,
  output logic                 mem_rd_en,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 mem_wr_en,
  output logic [DW-1:0]        mem_wdata,
  output logic [DW-1:0]        w_out,
  output logic [4:0]           status_out,
  output logic                 done
);
  localparam int AW = BANK_W + DW;

  phase_t phase_q, phase_d;
  op_t    op_q, dec_op;
  logic   dest_q, dec_dest, dec_bank;
  logic   accept;
  logic   op_is_and, op_is_nop;

  logic [DW-1:0]     dec_field, lit_q, opnd_q, res_q, w_q, alu_res;
  logic [AW-1:0]     map_addr, addr_q;
  logic [BANK_W-1:0] bsr_q;
  flags_t            st_q, flg_q, alu_flg;

  wexec_decode #(.DW(DW)) u_dec (
    .word      (instr_word),
    .op        (dec_op),
    .dest_file (dec_dest),
    .use_bank  (dec_bank),
    .field     (dec_field)
  );

  wexec_bankmap #(.DW(DW), .BANK_W(BANK_W), .ACCESS_SPLIT(ACCESS_SPLIT)) u_map (
    .field    (dec_field),
    .use_bank (dec_bank),
    .bank     (bsr_q),
    .addr     (map_addr)
  );

  wexec_alu #(.DW(DW)) u_alu (
    .op        (op_q),
    .w         (w_q),
    .opnd      (opnd_q),
    .flags_in  (st_q),
    .result    (alu_res),
    .flags_out (alu_flg)
  );

  assign instr_ready = (phase_q == PH_IDLE) || (phase_q == PH_Q4);
  assign accept      = instr_valid && instr_ready;

  always_comb begin
    phase_d = PH_IDLE;
    unique case (phase_q)
      PH_IDLE: phase_d = accept ? PH_Q1 : PH_IDLE;
      PH_Q1:   phase_d = PH_Q2;
      PH_Q2:   phase_d = PH_Q3;
      PH_Q3:   phase_d = PH_Q4;
      PH_Q4:   phase_d = accept ? PH_Q1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // sequencing and instruction capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_NOP;
      dest_q  <= 1'b0;
      lit_q   <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        op_q   <= dec_op;
        dest_q <= dec_dest;
        lit_q  <= dec_field;
        addr_q <= map_addr;
      end
    end
  end

  // operand capture (Q2) and compute (Q3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      res_q  <= '0;
      flg_q  <= '0;
    end else begin
      if (phase_q == PH_Q2) begin
        opnd_q <= (op_q == OP_ADDC) ? mem_rdata : lit_q;
      end
      if (phase_q == PH_Q3) begin
        res_q <= alu_res;
        flg_q <= alu_flg;
      end
    end
  end

  // architectural state: write-back in Q4
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      st_q  <= '0;
      bsr_q <= '0;
    end else begin
      if (bsr_wr_en) begin
        bsr_q <= bsr_wr_data;
      end
      if (phase_q == PH_Q4 && op_q != OP_NOP) begin
        st_q <= flg_q;
        if (op_q == OP_ANDL || !dest_q) begin
          w_q <= res_q;
        end
      end
    end
  end

  assign op_is_and  = (op_q == OP_ANDL);
  assign op_is_nop  = (op_q == OP_NOP);

  assign mem_addr   = addr_q;
  assign mem_rd_en  = (phase_q == PH_Q1) && (op_q == OP_ADDC);
  assign mem_wr_en  = (phase_q == PH_Q4) && (op_q == OP_ADDC) && dest_q;
  assign mem_wdata  = res_q;
  assign w_out      = w_q;
  assign status_out = st_q;
  assign done       = (phase_q == PH_Q4);

endmodule

// File: rtl/wexec_checks.sv
module wexec_checks #(
  parameter int DW     = 8,
  parameter int BANK_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 instr_ready,
  input logic                 done,
  input logic                 mem_rd_en,
  input logic                 mem_wr_en,
  input logic [BANK_W+DW-1:0] mem_addr,
  input logic [DW-1:0]        w_out,
  input logic [4:0]           status_out,
  input logic                 op_is_and,
  input logic                 op_is_nop
);

  p_busy_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !instr_ready);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_keeps_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> $stable(w_out));

  p_and_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_is_and) |=> ($stable(status_out[1:0]) && $stable(status_out[3])));

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_is_nop) |=> ($stable(w_out) && $stable(status_out)));

  p_read_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (!mem_rd_en && !done && $stable(mem_addr)));

  p_write_in_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (done && !mem_rd_en));

endmodule

bind wexec_core wexec_checks #(.DW(DW), .BANK_W(BANK_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .done        (done),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_addr    (mem_addr),
  .w_out       (w_out),
  .status_out  (status_out),
  .op_is_and   (op_is_and),
  .op_is_nop   (op_is_nop)
);

// File: tb/wexec_core_tb.sv
`timescale 1ns/1ps
module wexec_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0;
  logic        bsr_wr_en = 1'b0;
  logic [3:0]  bsr_wr_data = '0;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  w_out;
  logic [4:0]  status_out;
  logic        done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wexec_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .bsr_wr_en(bsr_wr_en), .bsr_wr_data(bsr_wr_data),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .w_out(w_out), .status_out(status_out), .done(done)
  );

  // bench memory: registered read, one cycle latency
  logic [7:0] mem [4096];
  logic [7:0] ref_mem [4096];
  logic [7:0] rdata_q = '0;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (mem_rd_en) rdata_q <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;
  logic [15:0] m_ins = '0;
  logic [11:0] m_addr = '0;
  logic [7:0]  m_w = '0;
  logic [4:0]  m_st = '0;
  logic [3:0]  m_bsr = '0;

  function automatic logic [11:0] map_addr(input logic [15:0] ins, input logic [3:0] bank);
    if (ins[8]) return {bank, ins[7:0]};
    if (ins[7:0] < 8'h60) return {4'h0, ins[7:0]};
    return {4'hF, ins[7:0]};
  endfunction

  function automatic bit is_add(input logic [15:0] ins);
    return ins[15:10] == 6'b001000;
  endfunction

  function automatic bit is_and(input logic [15:0] ins);
    return ins[15:8] == 8'h0B;
  endfunction

  function automatic logic [7:0] add_res(input int w, input int f, input int c);
    int s;
    s = w + f + c;
    return 8'(s);
  endfunction

  function automatic logic [4:0] add_flags(input int w, input int f, input int c);
    int s, lo, sw, sf, ss;
    logic n, ov, z, dc, cy;
    s  = w + f + c;
    lo = (w % 16) + (f % 16) + c;
    sw = (w > 127) ? w - 256 : w;
    sf = (f > 127) ? f - 256 : f;
    ss = sw + sf + c;
    cy = (s > 255);
    dc = (lo > 15);
    z  = ((s % 256) == 0);
    n  = ((s % 256) > 127);
    ov = (ss > 127) || (ss < -128);
    return {n, ov, z, dc, cy};
  endfunction

  task automatic commit();
    logic [7:0] fb, r;
    if (is_add(m_ins)) begin
      fb = ref_mem[m_addr];
      r  = add_res(m_w, fb, m_st[0]);
      m_st = add_flags(m_w, fb, m_st[0]);
      if (m_ins[9]) ref_mem[m_addr] = r;
      else m_w = r;
    end else if (is_and(m_ins)) begin
      r = m_w & m_ins[7:0];
      m_w = r;
      m_st[4] = r[7];
      m_st[2] = (r == 8'h00);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_w = '0; m_st = '0; m_bsr = '0;
    end else begin
      bit acc;
      acc = instr_valid && (m_phase == 0 || m_phase == 4);
      if (m_phase == 4) commit();
      if (acc) begin
        m_ins   = instr_word;
        m_addr  = map_addr(instr_word, m_bsr);
        m_phase = 1;
      end else if (m_phase == 4) begin
        m_phase = 0;
      end else if (m_phase != 0) begin
        m_phase = m_phase + 1;
      end
      if (bsr_wr_en) m_bsr = bsr_wr_data;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rd, e_wr;
      e_rd = (m_phase == 1) && is_add(m_ins);
      e_wr = (m_phase == 4) && is_add(m_ins) && m_ins[9];
      chk(instr_ready == (m_phase == 0 || m_phase == 4), "R1 ready", int'(instr_ready), int'(m_phase == 0 || m_phase == 4));
      chk(done == (m_phase == 4), "R2 done", int'(done), int'(m_phase == 4));
      chk(mem_rd_en == e_rd, "R10 read strobe", int'(mem_rd_en), int'(e_rd));
      chk(mem_wr_en == e_wr, "R4 write strobe", int'(mem_wr_en), int'(e_wr));
      if (e_rd || e_wr) begin
        if (m_ins[8]) chk(mem_addr == m_addr, "R6 banked address", int'(mem_addr), int'(m_addr));
        else          chk(mem_addr == m_addr, "R5 access address", int'(mem_addr), int'(m_addr));
      end
      if (e_wr) begin
        chk(mem_wdata == add_res(m_w, ref_mem[m_addr], m_st[0]), "R3 write data",
            int'(mem_wdata), int'(add_res(m_w, ref_mem[m_addr], m_st[0])));
      end
      chk(w_out == m_w, "R3 working register", int'(w_out), int'(m_w));
      chk(status_out == m_st, "R7 status", int'(status_out), int'(m_st));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [15:0] addc(input logic [7:0] f, input bit d, input bit a);
    return {6'b001000, d, a, f};
  endfunction

  function automatic logic [15:0] andl(input logic [7:0] k);
    return {8'h0B, k};
  endfunction

  task automatic poke(input int a, input logic [7:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  // called at a negedge; returns at the negedge after the word is taken
  task automatic issue(input logic [15:0] word, input bit with_bank = 1'b0, input logic [3:0] bank = '0);
    instr_word  = word;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    bsr_wr_en   = with_bank;
    bsr_wr_data = bank;
    @(negedge clk);
    instr_valid = 1'b0;
    bsr_wr_en   = 1'b0;
  endtask

  task automatic drain();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_bank(input logic [3:0] bank);
    bsr_wr_en   = 1'b1;
    bsr_wr_data = bank;
    @(negedge clk);
    bsr_wr_en   = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]     = 8'((i * 37 + 11) % 256);
      ref_mem[i] = 8'((i * 37 + 11) % 256);
    end
    poke('h020, 8'h4D); poke('h021, 8'hB3); poke('h022, 8'h02);
    poke('h023, 8'hA3); poke('h024, 8'h80); poke('hF80, 8'h10);
    poke('h510, 8'h20); poke('h910, 8'h01); poke('h030, 8'h40);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(w_out == 8'h00 && status_out == 5'h00, "R11 reset W/status", int'({w_out, 3'b0, status_out}), 0);
    chk(instr_ready && !done, "R11 reset ready/done", int'({instr_ready, done}), 2);

    // R3/R4/R7: load W, set carry by a file write, then the worked example
    issue(addc(8'h20, 1'b0, 1'b0));
    issue(addc(8'h21, 1'b1, 1'b0));
    issue(addc(8'h22, 1'b0, 1'b0));
    drain();
    chk(w_out == 8'h50, "R3 W after add with carry", int'(w_out), 'h50);
    chk(status_out[0] == 1'b0, "R7 carry cleared", int'(status_out[0]), 0);
    chk(mem['h022] == 8'h02, "R4 file unchanged with d=0", int'(mem['h022]), 'h02);
    chk(mem['h021] == 8'h00, "R4 file written with d=1", int'(mem['h021]), 'h00);

    // R8: AND-literal keeps C/DC/OV
    issue(andl(8'h00));
    issue(addc(8'h23, 1'b0, 1'b0));
    issue(addc(8'h24, 1'b1, 1'b0));
    issue(andl(8'h5F));
    drain();
    chk(w_out == 8'h03, "R8 W after AND literal", int'(w_out), 'h03);
    chk(status_out == 5'b01001, "R8 only N/Z touched", int'(status_out), 'b01001);

    // R5: access-bank upper region
    issue(addc(8'h80, 1'b0, 1'b0));
    drain();
    chk(w_out == 8'h14, "R5 read from F80h", int'(w_out), 'h14);

    // R6: banked access, then bank load on the acceptance edge
    load_bank(4'h5);
    issue(addc(8'h10, 1'b0, 1'b1));
    drain();
    chk(w_out == 8'h34, "R6 banked read", int'(w_out), 'h34);
    issue(addc(8'h10, 1'b0, 1'b1), 1'b1, 4'h9);
    issue(addc(8'h10, 1'b0, 1'b1));
    drain();
    chk(w_out == 8'h55, "R6 bank sampled at acceptance", int'(w_out), 'h55);

    // R10: back-to-back write then read of the same byte
    issue(addc(8'h30, 1'b1, 1'b0));
    issue(addc(8'h30, 1'b0, 1'b0));
    drain();
    chk(w_out == 8'hEA, "R10 read after back-to-back write", int'(w_out), 'hEA);

    // R9: unknown opcode
    issue(16'hFF00);
    drain();
    chk(w_out == 8'hEA, "R9 no-op keeps W", int'(w_out), 'hEA);

    // R8: negative AND result sets N
    issue(andl(8'hF0));
    drain();
    chk(w_out == 8'hE0 && status_out[4], "R8 N from AND", int'({status_out, w_out}), 'h10E0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule